// File: doc/BRIEF.md
# CD Sector Deframer

This block takes a raw CD data sector stream one byte at a time and puts it back into plain form. Each incoming byte first has its bit order swapped. While the block is hunting, it looks for the twelve-byte sector sync field. Once it has locked, it strips the scrambling from every byte that follows the sync, using a 15-bit LFSR. The first four plain bytes of each sector are the address and mode header. These are captured into output registers, checked for legal BCD and mode values, and flagged as ready, or as ready with an error.

Plain payload bytes go downstream only after the controller has issued a start command, and only from the first sector boundary after that command. Header capture and its status flags run whether or not payload is flowing, so the controller can follow the disc position before it enables the data path. When a sector ends, the block drops back to hunting. A missing sync is therefore recovered by finding the pattern wherever it next appears.

Both byte interfaces are valid/ready. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low only while an output byte is held and `out_ready` is low. Bytes that do not go downstream (sync bytes, bytes while hunting, bytes while the gate is closed) still obey this rule. An output byte, together with its `out_first` flag, is held stable until `out_ready` takes it.

Top module: `cd_sector_deframer`

## Requirements
- R1: After reset, `out_valid`, `hdr_ready` and `hdr_err` are 0, `in_ready` is 1, and the data gate is closed and not armed.
- R2: Every accepted byte is bit-reversed (new bit i = old bit 7-i) before sync matching and before descrambling.
- R3: Sector positions 12 to SECTOR_LEN-1 are XORed with a 15-bit LFSR key. The polynomial is x^15+x+1 and the register holds 0x0001 at position 12. Key bit i (LSB first) is state bit 0, after which the state shifts right and bit 0 XOR bit 1 enters bit 14.
- R4: While hunting, the block locks after the reversed bytes 00h, ten FFh, 00h, and the next byte becomes position 12. On a mismatch the match restarts, and a 00h byte counts as the first pattern byte.
- R5: After position SECTOR_LEN-1 the block hunts again. No byte is descrambled, captured or forwarded until a full sync pattern has been seen.
- R6: Plain bytes at positions 12, 13, 14 and 15 load `hdr_min`, `hdr_sec`, `hdr_frm` and `hdr_mode`. `hdr_ready` rises on the edge that accepts position 15, and both flags clear on the edge that completes the next sync.
- R7: `hdr_err` is set together with `hdr_ready` when any of these holds: a minutes, seconds or frames nibble is above 9; seconds is 60h or more; frames is 75h or more; or mode is above 02h.
- R8: Headers are captured while the data gate is closed, and no output byte appears while it is closed.
- R9: A one-cycle `start` arms the gate. The gate opens on the next completed sync and stays open until reset. Every position 12 to SECTOR_LEN-1 of each later sector is then forwarded in order, with `out_first` high only on position 12.
- R10: `in_ready` = !`out_valid` || `out_ready`. A held output byte and its `out_first` flag do not change until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that arms the data gate |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be accepted |
| in_data | input | 8 | Raw serial-order byte |
| out_valid | output | 1 | Plain payload byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Plain payload byte |
| out_first | output | 1 | Byte is sector position 12 |
| hdr_mode | output | 8 | Captured mode byte |
| hdr_min | output | 8 | Captured minutes byte |
| hdr_sec | output | 8 | Captured seconds byte |
| hdr_frm | output | 8 | Captured frames byte |
| hdr_ready | output | 1 | Header captured for current sector |
| hdr_err | output | 1 | Captured header has an illegal field |

## Verification
The first sector arrives with the gate closed. It shows whether headers are captured apart from the payload path. The next sector is preceded by partial sync patterns that break off at different depths, which separates a correct restart rule from one that loses a 00h that starts a new match. Back-to-back sectors, a sector followed by non-sync filler, and sectors carrying boundary headers (99h minutes, 59h and 60h seconds, 74h and 75h frames, modes 0 to 3, a non-BCD minutes nibble) tell apart the re-hunt path and each leg of the error rule. Random valid and ready gaps run throughout, so a payload mismatch points at the key sequence or the bit reversal rather than at a dropped or duplicated beat.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_EDGE = 8'h00;
  localparam logic [BYTE_W-1:0] SYNC_FILL = 8'hFF;
  localparam logic [BYTE_W-1:0] MODE_MAX  = 8'h02;
  localparam logic [BYTE_W-1:0] MIN_LIM   = 8'hA0;
  localparam logic [BYTE_W-1:0] SEC_LIM   = 8'h60;
  localparam logic [BYTE_W-1:0] FRM_LIM   = 8'h75;

  typedef enum logic {
    PH_HUNT   = 1'b0,
    PH_LOCKED = 1'b1
  } sdf_phase_e;

  // Both nibbles decimal and the whole value below the limit.
  function automatic logic bcd_below(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] lim);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9) && (b < lim);
  endfunction

endpackage

// File: rtl/sdf_bitrev.sv
module sdf_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/sdf_sync_fsm.sv
module sdf_sync_fsm
  import sdf_pkg::*;
#(
  parameter int SECTOR_LEN = 2352,
  parameter int SYNC_LEN   = 12,
  localparam int POS_W     = $clog2(SECTOR_LEN),
  localparam int CNT_W     = $clog2(SYNC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              locked_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              sync_done_o
);

  sdf_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  pos_q;
  logic [BYTE_W-1:0] want;
  logic              hit;
  logic              tail;

  assign tail = (cnt_q == CNT_W'(SYNC_LEN - 1));
  assign want = ((cnt_q == '0) || tail) ? SYNC_EDGE : SYNC_FILL;
  assign hit  = (byte_i == want);

  assign locked_o    = (phase_q == PH_LOCKED);
  assign pos_o       = pos_q;
  assign sync_done_o = (phase_q == PH_HUNT) && beat && hit && tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HUNT;
      cnt_q   <= '0;
      pos_q   <= '0;
    end else if (beat) begin
      unique case (phase_q)
        PH_HUNT: begin
          if (hit && tail) begin
            phase_q <= PH_LOCKED;
            pos_q   <= POS_W'(SYNC_LEN);
            cnt_q   <= '0;
          end else if (hit) begin
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= (byte_i == SYNC_EDGE) ? CNT_W'(1) : '0;
          end
        end
        PH_LOCKED: begin
          if (pos_q == POS_W'(SECTOR_LEN - 1)) begin
            phase_q <= PH_HUNT;
            pos_q   <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: phase_q <= PH_HUNT;
      endcase
    end
  end

  AST_POS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (pos_q >= POS_W'(SYNC_LEN)) && (pos_q <= POS_W'(SECTOR_LEN - 1))); // R5

  AST_MATCH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (cnt_q < CNT_W'(SYNC_LEN))); // R4

  AST_LOCK_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done_o |=> locked_o && (pos_q == POS_W'(SYNC_LEN))); // R4

endmodule

// File: rtl/sdf_lfsr.sv
module sdf_lfsr #(
  parameter int LFSR_W = 15,
  parameter int OUT_W  = 8,
  parameter logic [LFSR_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [OUT_W-1:0]  key_o
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] walk;

  // One output bit per shift, LSB first; taps at x^1 and x^0 feed the top.
  always_comb begin
    walk  = state_q;
    key_o = '0;
    for (int i = 0; i < OUT_W; i++) begin
      key_o[i] = walk[0];
      walk     = {walk[0] ^ walk[1], walk[LFSR_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     state_q <= SEED;
    else if (load)  state_q <= SEED;
    else if (step)  state_q <= walk;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R3

  AST_LFSR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == SEED)); // R3

endmodule

// File: rtl/sdf_hdr_capture.sv
module sdf_hdr_capture
  import sdf_pkg::*;
#(
  parameter int POS_W    = 12,
  parameter int SYNC_LEN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_done,
  input  logic              data_beat,
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] frm_o,
  output logic              ready_o,
  output logic              err_o
);

  localparam logic [POS_W-1:0] P_MIN  = POS_W'(SYNC_LEN);
  localparam logic [POS_W-1:0] P_SEC  = POS_W'(SYNC_LEN + 1);
  localparam logic [POS_W-1:0] P_FRM  = POS_W'(SYNC_LEN + 2);
  localparam logic [POS_W-1:0] P_MODE = POS_W'(SYNC_LEN + 3);

  logic bad;

  assign bad = !bcd_below(min_o, MIN_LIM) || !bcd_below(sec_o, SEC_LIM) ||
               !bcd_below(frm_o, FRM_LIM) || (byte_i > MODE_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o  <= '0;
      min_o   <= '0;
      sec_o   <= '0;
      frm_o   <= '0;
      ready_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (sync_done) begin
      ready_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (data_beat) begin
      if (pos == P_MIN) min_o <= byte_i;
      if (pos == P_SEC) sec_o <= byte_i;
      if (pos == P_FRM) frm_o <= byte_i;
      if (pos == P_MODE) begin
        mode_o  <= byte_i;
        ready_o <= 1'b1;
        err_o   <= bad;
      end
    end
  end

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ready_o); // R7

  AST_READY_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(data_beat) && ($past(pos) == P_MODE)); // R6

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> !ready_o && !err_o); // R6

endmodule

// File: rtl/cd_sector_deframer.sv
module cd_sector_deframer
  import sdf_pkg::*;
#(
  parameter int SECTOR_LEN = 2352,
  parameter int SYNC_LEN   = 12,
  parameter int LFSR_W     = 15,
  localparam int POS_W     = $clog2(SECTOR_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic [BYTE_W-1:0] hdr_mode,
  output logic [BYTE_W-1:0] hdr_min,
  output logic [BYTE_W-1:0] hdr_sec,
  output logic [BYTE_W-1:0] hdr_frm,
  output logic              hdr_ready,
  output logic              hdr_err
);

  logic              beat;
  logic              data_beat;
  logic              locked;
  logic              sync_done;
  logic [POS_W-1:0]  pos;
  logic [BYTE_W-1:0] rev;
  logic [BYTE_W-1:0] key;
  logic [BYTE_W-1:0] plain;
  logic              armed_q;
  logic              gate_q;

  assign in_ready  = !out_valid || out_ready;
  assign beat      = in_valid && in_ready;
  assign data_beat = locked && beat;
  assign plain     = rev ^ key;

  sdf_bitrev #(.W(BYTE_W)) u_rev (
    .din  (in_data),
    .dout (rev)
  );

  sdf_sync_fsm #(.SECTOR_LEN(SECTOR_LEN), .SYNC_LEN(SYNC_LEN)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (beat),
    .byte_i      (rev),
    .locked_o    (locked),
    .pos_o       (pos),
    .sync_done_o (sync_done)
  );

  sdf_lfsr #(.LFSR_W(LFSR_W), .OUT_W(BYTE_W), .SEED(LFSR_W'(1))) u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sync_done),
    .step  (data_beat),
    .key_o (key)
  );

  sdf_hdr_capture #(.POS_W(POS_W), .SYNC_LEN(SYNC_LEN)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_done (sync_done),
    .data_beat (data_beat),
    .pos       (pos),
    .byte_i    (plain),
    .mode_o    (hdr_mode),
    .min_o     (hdr_min),
    .sec_o     (hdr_sec),
    .frm_o     (hdr_frm),
    .ready_o   (hdr_ready),
    .err_o     (hdr_err)
  );

  // Start arms; the gate opens only at a sector boundary and then stays open.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      if (start) armed_q <= 1'b1;
      if (sync_done && armed_q) gate_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
    end else if (data_beat && gate_q) begin
      out_valid <= 1'b1;
      out_data  <= plain;
      out_first <= (pos == POS_W'(SYNC_LEN));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first)); // R10

  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R10

  AST_GATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |=> gate_q); // R9

  AST_CLOSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> !out_valid); // R8

endmodule

// File: tb/cd_sector_deframer_tb.sv
`timescale 1ns/1ps
module cd_sector_deframer_tb;

  localparam int SLEN  = 2352;
  localparam int SYN   = 12;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       out_first;
  logic [7:0] hdr_mode, hdr_min, hdr_sec, hdr_frm;
  logic       hdr_ready, hdr_err;

  always #2 clk = ~clk;

  cd_sector_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first),
    .hdr_mode(hdr_mode), .hdr_min(hdr_min), .hdr_sec(hdr_sec), .hdr_frm(hdr_frm),
    .hdr_ready(hdr_ready), .hdr_err(hdr_err)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit wd_hit  = 1'b0;
  int delivered = 0;

  logic [7:0] key_tab [SLEN];
  logic [7:0] src_q [$];

  // reference model state
  bit         m_lock, m_gate, m_armed, m_ov, m_of, m_hrdy, m_herr, took;
  int         m_cnt, m_pos;
  logic [7:0] m_od, m_min, m_sec, m_frm, m_mode;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic bit dec_ok(input logic [7:0] b, input int lim);
    int hi = int'(b) / 16;
    int lo = int'(b) % 16;
    return hi < 10 && lo < 10 && int'(b) < lim;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Reference model: updated on every edge from the requirement text.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_gate = 0; m_armed = 0; m_ov = 0; m_of = 0;
      m_hrdy = 0; m_herr = 0; m_cnt = 0; m_pos = 0; took = 0;
      m_od = 0; m_min = 0; m_sec = 0; m_frm = 0; m_mode = 0;
    end else begin
      bit rdy;
      rdy  = !m_ov || out_ready;
      took = in_valid && rdy;
      if (m_ov && out_ready) begin
        m_ov = 0;
        delivered++;
      end
      if (took) begin
        logic [7:0] r;
        r = rev8(in_data);
        if (!m_lock) begin
          logic [7:0] want;
          want = (m_cnt == 0 || m_cnt == SYN - 1) ? 8'h00 : 8'hFF;
          if (r == want) begin
            if (m_cnt == SYN - 1) begin
              m_lock = 1; m_pos = SYN; m_cnt = 0;
              if (m_armed) m_gate = 1;
              m_hrdy = 0; m_herr = 0;
            end else m_cnt++;
          end else m_cnt = (r == 8'h00) ? 1 : 0;
        end else begin
          logic [7:0] p;
          p = r ^ key_tab[m_pos - SYN];
          if (m_pos == SYN)     m_min = p;
          if (m_pos == SYN + 1) m_sec = p;
          if (m_pos == SYN + 2) m_frm = p;
          if (m_pos == SYN + 3) begin
            m_mode = p;
            m_hrdy = 1;
            m_herr = !dec_ok(m_min, 'hA0) || !dec_ok(m_sec, 'h60) ||
                     !dec_ok(m_frm, 'h75) || p > 8'h02;
          end
          if (m_gate) begin
            m_ov = 1; m_od = p; m_of = (m_pos == SYN);
          end
          if (m_pos == SLEN - 1) begin
            m_lock = 0; m_cnt = 0;
          end else m_pos++;
        end
      end
      if (start) m_armed = 1;
    end
  end

  task automatic compare_all();
    chk(in_ready == (!m_ov || out_ready), "R10", "in_ready", in_ready, !m_ov || out_ready);
    chk(out_valid == m_ov, "R8/R9", "out_valid", out_valid, m_ov);
    if (m_ov) begin
      chk(out_data == m_od, "R2/R3", "out_data", out_data, m_od);
      chk(out_first == m_of, "R9", "out_first", out_first, m_of);
    end
    chk(hdr_ready == m_hrdy, "R6", "hdr_ready", hdr_ready, m_hrdy);
    chk(hdr_err == m_herr, "R7", "hdr_err", hdr_err, m_herr);
    if (m_hrdy) begin
      chk({hdr_min, hdr_sec, hdr_frm, hdr_mode} == {m_min, m_sec, m_frm, m_mode},
          "R6", "header", {hdr_min, hdr_sec, hdr_frm, hdr_mode}, {m_min, m_sec, m_frm, m_mode});
    end
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input int vpct, input int rpct);
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) begin
      if (!wd_hit) begin
        wd_hit = 1;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      end
      return;
    end
    compare_all();
    start = 1'b0;
    if (took && in_valid) void'(src_q.pop_front());
    if (in_valid && !took && src_q.size() > 0) begin
      in_data = src_q[0];
    end else if (src_q.size() > 0 && $urandom_range(99) < vpct) begin
      in_valid = 1'b1;
      in_data  = src_q[0];
    end else begin
      in_valid = 1'b0;
    end
    out_ready = ($urandom_range(99) < rpct);
  endtask

  task automatic run_queue(input int vpct, input int rpct);
    while ((src_q.size() > 0 || in_valid) && !wd_hit) step(vpct, rpct);
  endtask

  task automatic add_sync();
    src_q.push_back(8'h00);
    for (int i = 0; i < 10; i++) src_q.push_back(8'hFF);
    src_q.push_back(8'h00);
  endtask

  task automatic add_sector(input logic [7:0] mn, input logic [7:0] sc,
                            input logic [7:0] fr, input logic [7:0] md, input int seed);
    add_sync();
    for (int p = SYN; p < SLEN; p++) begin
      logic [7:0] pl;
      if (p == SYN) pl = mn;
      else if (p == SYN + 1) pl = sc;
      else if (p == SYN + 2) pl = fr;
      else if (p == SYN + 3) pl = md;
      else pl = 8'((p * 13 + seed) & 255);
      src_q.push_back(rev8(pl ^ key_tab[p - SYN]));
    end
  endtask

  initial begin
    int st;
    void'($urandom(7));
    st = 1;
    for (int k = 0; k < SLEN; k++) begin
      logic [7:0] kb;
      for (int b = 0; b < 8; b++) begin
        int fb;
        kb[b] = st[0];
        fb = (st ^ (st >> 1)) & 1;
        st = (st >> 1) | (fb << 14);
      end
      key_tab[k] = kb;
    end

    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!out_valid && !hdr_ready && !hdr_err && in_ready, "R1", "reset outputs",
        {out_valid, hdr_ready, hdr_err, in_ready}, 4'b0001);

    // R8, R6: valid header captured with gate closed; no payload expected
    add_sector(8'h12, 8'h34, 8'h56, 8'h01, 3);
    run_queue(80, 100);
    repeat (4) step(0, 100);
    chk(delivered == 0, "R8", "bytes out while closed", delivered, 0);
    chk(hdr_ready && !hdr_err && hdr_min == 8'h12 && hdr_mode == 8'h01, "R6",
        "closed-gate header", {hdr_ready, hdr_err, hdr_min, hdr_mode}, {2'b10, 8'h12, 8'h01});

    // R9: arm the gate
    @(negedge clk);
    cyc++;
    compare_all();
    start = 1'b1;
    repeat (2) step(0, 100);

    // R4: partial sync runs restarting on a 00h, then a sector with frames 75h (R7)
    src_q.push_back(8'h00); src_q.push_back(8'hFF); src_q.push_back(8'hFF);
    src_q.push_back(8'hFF); src_q.push_back(8'h00);
    for (int i = 0; i < 10; i++) src_q.push_back(8'hFF);
    src_q.push_back(8'hFF); src_q.push_back(8'h00); src_q.push_back(8'hFF);
    add_sector(8'h00, 8'h02, 8'h75, 8'h02, 11);
    run_queue(70, 75);

    // R5: back-to-back sector, then filler with no sync, then a sector with seconds 60h
    add_sector(8'h99, 8'h59, 8'h74, 8'h00, 21);
    for (int i = 0; i < 30; i++) src_q.push_back(8'h5A);
    add_sector(8'h01, 8'h60, 8'h00, 8'h01, 33);
    run_queue(85, 60);

    // R7: mode above two, then a non-decimal minutes nibble
    add_sector(8'h45, 8'h00, 8'h10, 8'h03, 44);
    run_queue(90, 90);
    add_sector(8'h9A, 8'h10, 8'h20, 8'h02, 55);
    run_queue(90, 90);
    repeat (6) step(0, 100);

    // R9: whole payload of the five sectors after arming reached the output
    chk(delivered == 5 * (SLEN - SYN), "R9", "payload count", delivered, 5 * (SLEN - SYN));
    // R5: back in hunt after the last sector, nothing pending
    chk(!out_valid, "R5", "idle after last sector", out_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule